// File: doc/BRIEF.md
# Gate Edge, Toggle and Timed-Gate Utility

This block turns one sampled control signal into a small family of timing signals. It advances only on a sample tick. Two hysteresis detectors turn the gate sample and the reset sample into clean logic levels. From the gate level the block produces:

- a short pulse on each rising edge;
- a short pulse on each falling edge;
- a complementary toggle pair that changes state on every rising edge;
- a timed output gate that starts on a rising edge.

A rising edge that arrives while the timed gate is still open keeps the gate open for a full length after that edge. The gate does not drop and start again.

The gate length is a base count of sample ticks, scaled by a power of two given as a signed octave value. The reset level and a reset button both close the timed gate and return the toggle pair to its initial state. A bypass input freezes every detector and timer and forces all outputs low. When bypass is released, processing continues from the frozen state.

Top module: `trig_flipgate`

## Requirements
- R1: A detector goes high when its sample is at or above `HI_TH`, and goes low when its sample is at or below `LO_TH`. Between the two thresholds it keeps its previous level. The level is updated only on a tick that is not bypassed.
- R2: Each low-to-high change of the gate level makes `trig_rise` high for `TRIG_TICKS` ticks. Each high-to-low change makes `trig_fall` high for `TRIG_TICKS` ticks. A new edge during a pulse restarts that pulse. Reset and length have no effect on either pulse.
- R3: `flip` is 1 after reset, and `flop` is always its inverse while not bypassed. Each rising gate edge inverts both, unless reset is active on that tick.
- R4: A rising gate edge sets the remaining gate time to the larger of the time still left and the scaled length L. As a result `gate_out` stays high until L ticks after the latest rising edge.
- R5: Reset is active on a tick when the reset detector level is high or `rst_btn` is 1. On such a tick the timed gate closes and `flip` is forced to 1.
- R6: The base length is first clamped to the range `LEN_MIN`..`LEN_MAX`. It is then multiplied by 2^`len_mod` (`len_mod` is signed two's complement). A negative `len_mod` shifts right, and a result of 0 becomes 1. A result larger than 2^`CNT_W`-1 saturates to that value.
- R7: While `bypass` is 1, all five outputs are 0 and no detector, pulse, toggle or timer state changes. Input changes during bypass are ignored.
- R8: On the first tick after bypass is released, the frozen detector levels are compared with the current samples. For example, a gate level that was high before bypass and is low at release fires `trig_fall` on that tick. Timers continue from their frozen counts.
- R9: In a clock cycle without `tick`, no state or output changes.
- R10: After the asynchronous reset, `flip` is 1 and all other outputs are 0. The reset is released internally through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate enable |
| bypass | input | 1 | Freeze all state and force outputs low |
| gate_smp | input | SAMPLE_W | Signed gate sample |
| rst_smp | input | SAMPLE_W | Signed reset sample |
| rst_btn | input | 1 | Reset button level |
| len_base | input | CNT_W | Base gate length in ticks |
| len_mod | input | MOD_W | Signed octave scaling of the length |
| trig_rise | output | 1 | Rising-edge pulse |
| trig_fall | output | 1 | Falling-edge pulse |
| flip | output | 1 | Toggle output, starts high |
| flop | output | 1 | Inverse of flip |
| gate_out | output | 1 | Timed, retriggerable gate |

## Verification
The bench drives samples that sit between the two thresholds, to check the hysteresis. A detector with a single threshold would produce extra edges, and these show up as spurious pulses and toggles. It retriggers the timed gate in the middle of a gate. A design that adds the lengths together would hold the gate open too long, and a design that restarts the gate would show a low cycle. It covers every clamp and saturation case of the scaler, including a base below the minimum, a base above the maximum, a large shift and a deep negative shift. An unsaturated or wrapped length gives a gate that is far too short. Finally, it toggles the inputs during bypass and releases bypass with the gate low. A design that cleared its state on bypass, or that tracked inputs during bypass, would either miss the falling pulse at release or lose the remaining gate time.

// File: rtl/gk_pkg.sv
package gk_pkg;
  // index of the two edge pulse generators
  typedef enum int {
    EDGE_RISE = 0,
    EDGE_FALL = 1
  } edge_idx_e;

  localparam int NUM_EDGE = 2;
endpackage

// File: rtl/gk_hyst_det.sv
module gk_hyst_det #(
  parameter int SAMPLE_W = 16,
  parameter int HI_TH    = 2000,
  parameter int LO_TH    = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       level,
  output logic                       rise,
  output logic                       fall
);
  localparam logic signed [SAMPLE_W-1:0] HI_S = SAMPLE_W'(HI_TH);
  localparam logic signed [SAMPLE_W-1:0] LO_S = SAMPLE_W'(LO_TH);

  logic lvl_q;
  logic lvl_d;

  // next level: set at or above the high threshold, clear at or below the low one
  always_comb begin
    lvl_d = lvl_q;
    if (sample >= HI_S) begin
      lvl_d = 1'b1;
    end else if (sample <= LO_S) begin
      lvl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (en) begin
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_d & en | lvl_q & ~en;
  assign rise  = en & lvl_d & ~lvl_q;
  assign fall  = en & ~lvl_d & lvl_q;
endmodule

// File: rtl/gk_len_scale.sv
module gk_len_scale #(
  parameter int CNT_W   = 24,
  parameter int MOD_W   = 4,
  parameter int LEN_MIN = 48,
  parameter int LEN_MAX = 480000
) (
  input  logic        [CNT_W-1:0] base,
  input  logic signed [MOD_W-1:0] mod,
  output logic        [CNT_W-1:0] len
);
  localparam int SHMAX = 1 << (MOD_W - 1);
  localparam int WIDE  = CNT_W + SHMAX;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(LEN_MIN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(LEN_MAX);

  logic [CNT_W-1:0] base_c;
  logic [MOD_W-1:0] mag;
  logic [WIDE-1:0]  up;
  logic [CNT_W-1:0] down;

  always_comb begin
    if (base < MIN_C) begin
      base_c = MIN_C;
    end else if (base > MAX_C) begin
      base_c = MAX_C;
    end else begin
      base_c = base;
    end
  end

  assign mag  = mod[MOD_W-1] ? MOD_W'(-mod) : MOD_W'(mod);
  assign up   = {{SHMAX{1'b0}}, base_c} << mag;
  assign down = base_c >> mag;

  always_comb begin
    if (!mod[MOD_W-1]) begin
      if (|up[WIDE-1:CNT_W]) begin
        len = '1;
      end else begin
        len = up[CNT_W-1:0];
      end
    end else begin
      if (down == '0) begin
        len = CNT_W'(1);
      end else begin
        len = down;
      end
    end
  end
endmodule

// File: rtl/gk_countdown.sv
module gk_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clear,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] dec;

  assign dec = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);

  // start keeps the larger of what is left and a fresh load
  always_comb begin
    if (clear) begin
      cnt_d = '0;
    end else if (start) begin
      cnt_d = (dec > load) ? dec : load;
    end else begin
      cnt_d = dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/trig_flipgate.sv
module trig_flipgate #(
  parameter int SAMPLE_W   = 16,
  parameter int HI_TH      = 2000,
  parameter int LO_TH      = 100,
  parameter int CNT_W      = 24,
  parameter int MOD_W      = 4,
  parameter int LEN_MIN    = 48,
  parameter int LEN_MAX    = 480000,
  parameter int TRIG_TICKS = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       bypass,
  input  logic signed [SAMPLE_W-1:0] gate_smp,
  input  logic signed [SAMPLE_W-1:0] rst_smp,
  input  logic                       rst_btn,
  input  logic        [CNT_W-1:0]    len_base,
  input  logic signed [MOD_W-1:0]    len_mod,
  output logic                       trig_rise,
  output logic                       trig_fall,
  output logic                       flip,
  output logic                       flop,
  output logic                       gate_out
);
  import gk_pkg::*;

  localparam logic [CNT_W-1:0] TRIG_LOAD = CNT_W'(TRIG_TICKS);

  logic [1:0]          rst_pipe;
  logic                rst_i_n;
  logic                run;
  logic                g_level;
  logic                g_rise;
  logic                g_fall;
  logic                r_level;
  logic                r_rise_unused;
  logic                r_fall_unused;
  logic                rst_any;
  logic [CNT_W-1:0]    gate_len;
  logic                gate_busy;
  logic [NUM_EDGE-1:0] edge_hit;
  logic [NUM_EDGE-1:0] edge_busy;
  logic                flip_q;
  logic                flip_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe[1];

  assign run = tick & ~bypass;

  gk_hyst_det #(.SAMPLE_W(SAMPLE_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) gate_det_i (
    .clk(clk), .rst_n(rst_i_n), .en(run), .sample(gate_smp),
    .level(g_level), .rise(g_rise), .fall(g_fall)
  );

  gk_hyst_det #(.SAMPLE_W(SAMPLE_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) rst_det_i (
    .clk(clk), .rst_n(rst_i_n), .en(run), .sample(rst_smp),
    .level(r_level), .rise(r_rise_unused), .fall(r_fall_unused)
  );

  assign rst_any = r_level | rst_btn;

  gk_len_scale #(.CNT_W(CNT_W), .MOD_W(MOD_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) scale_i (
    .base(len_base), .mod(len_mod), .len(gate_len)
  );

  assign edge_hit[EDGE_RISE] = g_rise;
  assign edge_hit[EDGE_FALL] = g_fall;

  for (genvar e = 0; e < NUM_EDGE; e++) begin : g_edge
    gk_countdown #(.CNT_W(CNT_W)) pulse_i (
      .clk(clk), .rst_n(rst_i_n), .en(run), .clear(1'b0),
      .start(edge_hit[e]), .load(TRIG_LOAD), .busy(edge_busy[e])
    );
  end

  gk_countdown #(.CNT_W(CNT_W)) gate_tmr_i (
    .clk(clk), .rst_n(rst_i_n), .en(run), .clear(rst_any),
    .start(g_rise), .load(gate_len), .busy(gate_busy)
  );

  always_comb begin
    flip_d = flip_q;
    if (rst_any) begin
      flip_d = 1'b1;
    end else if (g_rise) begin
      flip_d = ~flip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flip_q <= 1'b1;
    end else if (run) begin
      flip_q <= flip_d;
    end
  end

  assign trig_rise = edge_busy[EDGE_RISE] & ~bypass;
  assign trig_fall = edge_busy[EDGE_FALL] & ~bypass;
  assign flip      = flip_q & ~bypass;
  assign flop      = ~flip_q & ~bypass;
  assign gate_out  = gate_busy & ~bypass;
endmodule

// File: rtl/gk_checker.sv
module gk_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic bypass,
  input logic g_rise,
  input logic rst_any,
  input logic flip_q,
  input logic gate_busy,
  input logic trig_rise,
  input logic trig_fall,
  input logic flip,
  input logic flop,
  input logic gate_out
);
  assert_flop_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (flop == !flip));

  assert_toggle_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass && g_rise && !rst_any) |=> (flip_q != $past(flip_q)));

  assert_rise_opens_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass && g_rise && !rst_any) |=> gate_busy);

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass && rst_any) |=> (!gate_busy && flip_q));

  assert_bypass_outputs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !(trig_rise || trig_fall || flip || flop || gate_out));

  assert_bypass_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> ($stable(gate_busy) && $stable(flip_q)));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bypass) ##1 !bypass |-> ($stable(gate_out) && $stable(flip) &&
                                         $stable(trig_rise) && $stable(trig_fall)));
endmodule

bind trig_flipgate gk_checker chk_i (
  .clk(clk), .rst_n(rst_i_n), .tick(tick), .bypass(bypass),
  .g_rise(g_rise), .rst_any(rst_any), .flip_q(flip_q), .gate_busy(gate_busy),
  .trig_rise(trig_rise), .trig_fall(trig_fall), .flip(flip), .flop(flop),
  .gate_out(gate_out)
);

// File: tb/trig_flipgate_tb_top.sv
module trig_flipgate_tb_top;
  localparam int SW = 16;
  localparam int HI = 2000;
  localparam int LO = 100;
  localparam int CW = 8;
  localparam int MW = 4;
  localparam int LMIN = 2;
  localparam int LMAX = 40;
  localparam int TT = 3;
  localparam int SAT = (1 << CW) - 1;

  localparam logic signed [SW-1:0] V_HI  = 16'sd3000;
  localparam logic signed [SW-1:0] V_MID = 16'sd1000;
  localparam logic signed [SW-1:0] V_LO  = 16'sd50;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic bypass;
  logic signed [SW-1:0] gate_smp;
  logic signed [SW-1:0] rst_smp;
  logic rst_btn;
  logic [CW-1:0] len_base;
  logic signed [MW-1:0] len_mod;
  logic trig_rise, trig_fall, flip, flop, gate_out;

  always #5 clk = ~clk;

  trig_flipgate #(.SAMPLE_W(SW), .HI_TH(HI), .LO_TH(LO), .CNT_W(CW), .MOD_W(MW),
                  .LEN_MIN(LMIN), .LEN_MAX(LMAX), .TRIG_TICKS(TT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bypass(bypass),
    .gate_smp(gate_smp), .rst_smp(rst_smp), .rst_btn(rst_btn),
    .len_base(len_base), .len_mod(len_mod),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .flip(flip), .flop(flop),
    .gate_out(gate_out)
  );

  typedef struct {
    logic  r, f, fl, fo, g;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, from the requirements
  bit m_g = 0, m_r = 0, m_flip = 1;
  int m_rc = 0, m_fc = 0, m_gc = 0;

  function automatic int scaled(int b, int m);
    int c, v;
    c = (b < LMIN) ? LMIN : (b > LMAX) ? LMAX : b;
    if (m >= 0) begin
      v = c << m;
      if (v > SAT) v = SAT;
    end else begin
      v = c >> (-m);
      if (v == 0) v = 1;
    end
    return v;
  endfunction

  task automatic step(input bit tk, input logic signed [SW-1:0] gv,
                      input logic signed [SW-1:0] rv, input bit btn,
                      input int base, input int md, input bit byp, input string tag);
    bit ng, nr, rise, fall, ra;
    int dg, L;
    exp_t e;
    @(negedge clk);
    tick = tk; gate_smp = gv; rst_smp = rv; rst_btn = btn;
    len_base = CW'(base); len_mod = MW'(md); bypass = byp;
    if (tk && !byp) begin
      ng = (gv >= HI) ? 1'b1 : (gv <= LO) ? 1'b0 : m_g;
      nr = (rv >= HI) ? 1'b1 : (rv <= LO) ? 1'b0 : m_r;
      rise = ng && !m_g;
      fall = !ng && m_g;
      ra = nr || btn;
      m_rc = rise ? TT : (m_rc > 0 ? m_rc - 1 : 0);
      m_fc = fall ? TT : (m_fc > 0 ? m_fc - 1 : 0);
      dg = m_gc > 0 ? m_gc - 1 : 0;
      L = scaled(base, md);
      if (ra) m_gc = 0;
      else if (rise) m_gc = (dg > L) ? dg : L;
      else m_gc = dg;
      if (ra) m_flip = 1;
      else if (rise) m_flip = !m_flip;
      m_g = ng;
      m_r = nr;
    end
    e.r  = !byp && (m_rc != 0);
    e.f  = !byp && (m_fc != 0);
    e.fl = !byp && m_flip;
    e.fo = !byp && !m_flip;
    e.g  = !byp && (m_gc != 0);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n, input logic signed [SW-1:0] gv,
                     input logic signed [SW-1:0] rv, input bit btn,
                     input int base, input int md, input bit byp, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, gv, rv, btn, base, md, byp, tag);
  endtask

  // monitor: compares one expected item per cycle, after the edge settles
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({trig_rise, trig_fall, flip, flop, gate_out} !== {e.r, e.f, e.fl, e.fo, e.g}) begin
        errors++;
        $display("FAIL %s: got rise/fall/flip/flop/gate=%b expected %b at %0t", e.tag,
                 {trig_rise, trig_fall, flip, flop, gate_out},
                 {e.r, e.f, e.fl, e.fo, e.g}, $time);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; bypass = 0; gate_smp = V_LO; rst_smp = V_LO;
    rst_btn = 0; len_base = 8'd10; len_mod = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R10 reset state
    step(0, V_LO, V_LO, 0, 10, 0, 0, "R10 reset state");
    // R9 no tick: high sample without tick changes nothing
    step(0, V_HI, V_LO, 0, 10, 0, 0, "R9 no tick");
    step(0, V_HI, V_LO, 0, 10, 0, 0, "R9 no tick");
    run(2, V_LO, V_LO, 0, 10, 0, 0, "R1 idle low");
    // R1 R2 R3 R4 rising edge, middle value holds level, then falling edge
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R2 R3 R4 rise");
    run(12, V_MID, V_LO, 0, 10, 0, 0, "R1 R4 hold mid");
    run(5, V_LO, V_LO, 0, 10, 0, 0, "R2 fall");
    run(3, V_MID, V_LO, 0, 10, 0, 0, "R1 mid from low");
    // R4 retrigger extends gate
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R4 first rise");
    run(4, V_HI, V_LO, 0, 10, 0, 0, "R4 hold");
    run(1, V_LO, V_LO, 0, 10, 0, 0, "R4 drop");
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R4 retrigger");
    run(12, V_HI, V_LO, 0, 10, 0, 0, "R4 extended gate");
    run(2, V_LO, V_LO, 0, 10, 0, 0, "R4 low");
    // R5 button reset in the middle of a gate
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R5 rise");
    run(2, V_HI, V_LO, 0, 10, 0, 0, "R5 gate open");
    run(1, V_HI, V_LO, 1, 10, 0, 0, "R5 button");
    run(2, V_LO, V_LO, 0, 10, 0, 0, "R5 after button");
    // R5 reset through detector, rise while held: pulse but no toggle
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R5 rise again");
    run(1, V_LO, V_HI, 0, 10, 0, 0, "R2 R5 reset sample high");
    run(1, V_HI, V_MID, 0, 10, 0, 0, "R2 R5 rise under reset");
    run(3, V_LO, V_MID, 0, 10, 0, 0, "R5 held reset");
    run(2, V_LO, V_LO, 0, 10, 0, 0, "R5 reset released");
    // R6 length scaling variants
    run(1, V_HI, V_LO, 0, 8, 1, 0, "R6 double");
    run(18, V_LO, V_LO, 0, 8, 1, 0, "R6 double run");
    run(1, V_HI, V_LO, 0, 8, -2, 0, "R6 quarter");
    run(4, V_LO, V_LO, 0, 8, -2, 0, "R6 quarter run");
    run(1, V_HI, V_LO, 0, 2, -5, 0, "R6 floor one");
    run(3, V_LO, V_LO, 0, 2, -5, 0, "R6 floor run");
    run(1, V_HI, V_LO, 0, 0, 0, 0, "R6 clamp min");
    run(3, V_LO, V_LO, 0, 0, 0, 0, "R6 clamp min run");
    run(1, V_HI, V_LO, 0, 100, 0, 0, "R6 clamp max");
    run(42, V_LO, V_LO, 0, 100, 0, 0, "R6 clamp max run");
    run(1, V_HI, V_LO, 0, 40, 3, 0, "R6 saturate");
    run(258, V_LO, V_LO, 0, 40, 3, 0, "R6 saturate run");
    // R7 R8 bypass freeze and release
    run(1, V_HI, V_LO, 0, 10, 0, 0, "R7 rise before bypass");
    run(2, V_HI, V_LO, 0, 10, 0, 0, "R7 pre");
    run(2, V_LO, V_LO, 0, 10, 0, 1, "R7 bypass low in");
    run(2, V_HI, V_HI, 1, 10, 0, 1, "R7 bypass noisy in");
    run(1, V_LO, V_LO, 0, 10, 0, 1, "R7 bypass");
    step(0, V_LO, V_LO, 0, 10, 0, 0, "R8 released no tick");
    run(1, V_LO, V_LO, 0, 10, 0, 0, "R8 fall at release");
    run(10, V_LO, V_LO, 0, 10, 0, 0, "R8 resume gate");
    @(negedge clk); tick = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule